// File: doc/BRIEF.md
# UART Request and Status Register Logic

This block holds the command and status logic of a UART that has a transmit FIFO and a receive FIFO. Software writes a word to the request register to start one of four actions: discard the whole transmit FIFO, discard pending receive data, put the receiver into mute mode, or send a break character. Each action comes out as a pulse to the FIFOs and the transmitter nearby. The request bits are never stored, so reading the request register returns zero.

The block also assembles the 32-bit status word that software reads. That word holds the transmit FIFO empty and not-full flags, the receive not-empty flag, transmission complete, break pending and the receiver wake-up flag. Some requests leave effects in the status word. A transmit flush forces the not-full flag low until the FIFO reports empty, and the block refuses transmit data pushes during that time. A break request stays pending until the transmitter is idle, then goes out as a one-cycle request and clears when the transmitter reports that the break is finished. The serializer, the baud timing, the receiver, wake-up detection and interrupts are outside this block and reach it only as input levels and strobes.

Top module: `uart_req_status`

## Requirements
- R1: After reset, a read of address 0x1C returns 0x0080_00C0. Bit 23 is transmit FIFO empty, bit 7 is transmit FIFO not-full, bit 6 is transmission complete, and every unused bit reads as zero.
- R2: A read of the request register at 0x18, or of any address other than 0x1C, returns zero.
- R3: A write to 0x18 with bit 4 set drives `txFlushReq` high during that write cycle only. Bit 3 does the same for `rxFlushReq` and bit 2 for `muteReq`. Bits that are set together give their pulses in the same cycle.
- R4: From the clock edge that takes a transmit flush write, status bit 7 reads 0 and `txPush` stays low whatever `txDataWrite` is. Both return only at the edge after which `txFifoEmpty` is seen high.
- R5: Status bit 23 follows `txFifoEmpty`, bit 6 follows `txComplete`, and bit 7 is 0 while `txFifoFull` is high. Each flag is registered and appears one edge after its input changes.
- R6: A write with bit 3 set clears status bit 5 (receive not-empty) from the next edge. The bit stays clear while `rxFifoNotEmpty` stays high, and it reflects new data again only after that input has been seen low.
- R7: A `wakeEvent` pulse sets status bit 19. A write with bit 2 set clears it. If both happen in the same cycle, the write wins.
- R8: A write with bit 1 set makes status bit 18 (break pending) read 1 from the next edge. A further break write while the break is pending changes nothing.
- R9: While a break is pending, `breakReq` is low as long as `txIdle` is low. It goes high for exactly one cycle once `txIdle` is high. Bit 18 clears at the edge that takes `breakDone`.
- R10: Request bit 0, bits 31:5, and writes to any address other than 0x18 cause no pulse and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte address of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, combinational |
| txFifoEmpty | input | 1 | Transmit FIFO holds no data |
| txFifoFull | input | 1 | Transmit FIFO has no free entry |
| rxFifoNotEmpty | input | 1 | Receive FIFO holds data |
| txComplete | input | 1 | Last frame has left the line |
| txIdle | input | 1 | Transmitter can take a break |
| breakDone | input | 1 | Break character finished |
| wakeEvent | input | 1 | Receiver wake-up detected |
| txDataWrite | input | 1 | Software tries to push transmit data |
| txFlushReq | output | 1 | Flush pulse to the transmit FIFO |
| rxFlushReq | output | 1 | Discard pulse to the receive FIFO |
| muteReq | output | 1 | Mute entry pulse to the receiver |
| breakReq | output | 1 | One-cycle break request to the transmitter |
| txPush | output | 1 | Transmit push accepted |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 32-bit data word, and the request and status registers at 0x18 and 0x1C. With these values every status bit position and every reserved request bit is reachable through the bus. The bench can then hold a flush open for several cycles against a non-empty FIFO, keep a break pending against a busy transmitter, and make a mute write and a wake event collide in one cycle.

// File: rtl/uart_req_pkg.sv
package uart_req_pkg;

  // request bit positions (software writes these)
  localparam int REQ_TXFLUSH_BIT = 4;
  localparam int REQ_RXFLUSH_BIT = 3;
  localparam int REQ_MUTE_BIT    = 2;
  localparam int REQ_BREAK_BIT   = 1;

  // status bit positions that this block drives
  localparam int ST_RXFNE_BIT = 5;
  localparam int ST_TC_BIT    = 6;
  localparam int ST_TXFNF_BIT = 7;
  localparam int ST_SBKF_BIT  = 18;
  localparam int ST_RWU_BIT   = 19;
  localparam int ST_TXFE_BIT  = 23;

  typedef struct packed {
    logic txFlush;
    logic rxFlush;
    logic mute;
    logic brk;
  } reqStrobes_t;

endpackage

// File: rtl/uart_req_ctrl.sv
module uart_req_ctrl
  import uart_req_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REQ_OFFSET  = 'h18,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] statusWord,
  output reqStrobes_t       strobes,
  output logic [DATA_W-1:0] busRdata
);

  logic reqHit;
  logic statHit;
  logic unusedWdata;

  assign reqHit  = busSel && busWrite && (busAddr == REQ_OFFSET);
  assign statHit = busSel && !busWrite && (busAddr == STAT_OFFSET);

  // reserved request bits are ignored (R10)
  assign unusedWdata = ^busWdata;

  always_comb begin
    strobes         = '0;
    strobes.txFlush = reqHit && busWdata[REQ_TXFLUSH_BIT];
    strobes.rxFlush = reqHit && busWdata[REQ_RXFLUSH_BIT];
    strobes.mute    = reqHit && busWdata[REQ_MUTE_BIT];
    strobes.brk     = reqHit && busWdata[REQ_BREAK_BIT];
  end

  // request register is write-only: only the status address returns data
  assign busRdata = statHit ? statusWord : '0;

  p_strobe_needs_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes != '0) |-> (busSel && busWrite));

  p_req_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == REQ_OFFSET) |-> (busRdata == '0));

endmodule

// File: rtl/uart_req_status_path.sv
module uart_req_status_path
  import uart_req_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  reqStrobes_t       strobes,
  input  logic              txFifoEmpty,
  input  logic              txFifoFull,
  input  logic              rxFifoNotEmpty,
  input  logic              txComplete,
  input  logic              txIdle,
  input  logic              breakDone,
  input  logic              wakeEvent,
  input  logic              txDataWrite,
  output logic [DATA_W-1:0] statusWord,
  output logic              breakReq,
  output logic              txPush
);

  logic txfeQ, tcQ, txFullQ, rxNeQ;
  logic flushBusy, rxDiscard;
  logic rwuQ, sbkfQ, brkIssued;
  logic txNotFull, rxNotEmptyFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txfeQ     <= 1'b1;
      tcQ       <= 1'b1;
      txFullQ   <= 1'b0;
      rxNeQ     <= 1'b0;
      flushBusy <= 1'b0;
      rxDiscard <= 1'b0;
      rwuQ      <= 1'b0;
      sbkfQ     <= 1'b0;
      brkIssued <= 1'b0;
    end else begin
      txfeQ   <= txFifoEmpty;
      tcQ     <= txComplete;
      txFullQ <= txFifoFull;
      rxNeQ   <= rxFifoNotEmpty;

      if (strobes.txFlush)  flushBusy <= 1'b1;
      else if (txFifoEmpty) flushBusy <= 1'b0;

      if (strobes.rxFlush)      rxDiscard <= 1'b1;
      else if (!rxFifoNotEmpty) rxDiscard <= 1'b0;

      if (strobes.mute)   rwuQ <= 1'b0;
      else if (wakeEvent) rwuQ <= 1'b1;

      if (breakDone) begin
        sbkfQ     <= strobes.brk;
        brkIssued <= 1'b0;
      end else begin
        if (strobes.brk) sbkfQ     <= 1'b1;
        if (breakReq)    brkIssued <= 1'b1;
      end
    end
  end

  assign txNotFull      = !txFullQ && !flushBusy;
  assign rxNotEmptyFlag = rxNeQ && !rxDiscard;
  assign breakReq       = sbkfQ && !brkIssued && txIdle;
  assign txPush         = txDataWrite && txNotFull;

  always_comb begin
    statusWord               = '0;
    statusWord[ST_RXFNE_BIT] = rxNotEmptyFlag;
    statusWord[ST_TC_BIT]    = tcQ;
    statusWord[ST_TXFNF_BIT] = txNotFull;
    statusWord[ST_SBKF_BIT]  = sbkfQ;
    statusWord[ST_RWU_BIT]   = rwuQ;
    statusWord[ST_TXFE_BIT]  = txfeQ;
  end

  p_txfnf_low_on_flush_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txFlush |=> !statusWord[ST_TXFNF_BIT]);

  p_txfnf_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[ST_TXFNF_BIT] && !txFifoEmpty && !txFifoFull && flushBusy)
      |=> !statusWord[ST_TXFNF_BIT]);

  p_rxfne_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxFlush |=> !statusWord[ST_RXFNE_BIT]);

  p_rwu_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mute |=> !statusWord[ST_RWU_BIT]);

  p_sbkf_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.brk |=> statusWord[ST_SBKF_BIT]);

  p_brk_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |=> !breakReq);

  p_brk_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> (txIdle && statusWord[ST_SBKF_BIT]));

endmodule

// File: rtl/uart_req_status.sv
module uart_req_status
  import uart_req_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REQ_OFFSET  = 'h18,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              txFifoEmpty,
  input  logic              txFifoFull,
  input  logic              rxFifoNotEmpty,
  input  logic              txComplete,
  input  logic              txIdle,
  input  logic              breakDone,
  input  logic              wakeEvent,
  input  logic              txDataWrite,
  output logic              txFlushReq,
  output logic              rxFlushReq,
  output logic              muteReq,
  output logic              breakReq,
  output logic              txPush
);

  reqStrobes_t       strobes;
  logic [DATA_W-1:0] statusWord;

  uart_req_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REQ_OFFSET(REQ_OFFSET), .STAT_OFFSET(STAT_OFFSET)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .statusWord(statusWord),
    .strobes(strobes), .busRdata(busRdata)
  );

  uart_req_status_path #(.DATA_W(DATA_W)) path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txFifoEmpty(txFifoEmpty), .txFifoFull(txFifoFull),
    .rxFifoNotEmpty(rxFifoNotEmpty), .txComplete(txComplete),
    .txIdle(txIdle), .breakDone(breakDone), .wakeEvent(wakeEvent),
    .txDataWrite(txDataWrite), .statusWord(statusWord),
    .breakReq(breakReq), .txPush(txPush)
  );

  assign txFlushReq = strobes.txFlush;
  assign rxFlushReq = strobes.rxFlush;
  assign muteReq    = strobes.mute;

endmodule

// File: tb/tb_uart_req_status.sv
`timescale 1ns/1ps
module tb_uart_req_status;

  localparam logic [7:0] REQ  = 8'h18;
  localparam logic [7:0] STAT = 8'h1C;
  localparam logic [31:0] BASE = 32'h0080_00C0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busWrite = 0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic txFifoEmpty = 1, txFifoFull = 0, rxFifoNotEmpty = 0, txComplete = 1;
  logic txIdle = 1, breakDone = 0, wakeEvent = 0, txDataWrite = 0;
  logic txFlushReq, rxFlushReq, muteReq, breakReq, txPush;

  int total = 0, bad = 0;
  logic rdPending = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic [3:0] cap;  // {tx, rx, mute, break} seen in the write cycle

  always #10 clk = ~clk;

  uart_req_status dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txFifoEmpty(txFifoEmpty), .txFifoFull(txFifoFull),
    .rxFifoNotEmpty(rxFifoNotEmpty), .txComplete(txComplete),
    .txIdle(txIdle), .breakDone(breakDone), .wakeEvent(wakeEvent),
    .txDataWrite(txDataWrite), .txFlushReq(txFlushReq),
    .rxFlushReq(rxFlushReq), .muteReq(muteReq), .breakReq(breakReq),
    .txPush(txPush)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: compares every read against the queued expectation
  always @(negedge clk) begin
    if (rdPending && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(busRdata, e, t);
    end
  end

  task automatic readReg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    busSel = 1; busWrite = 0; busAddr = a; rdPending = 1;
    @(posedge clk); #1;
    busSel = 0; rdPending = 0;
  endtask

  task automatic writeReq(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    cap = {txFlushReq, rxFlushReq, muteReq, breakReq};
    @(posedge clk); #1;
    busSel = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    // R1 reset state
    readReg(STAT, BASE, "R1 reset status");
    // R2 request register and unmapped address read zero
    readReg(REQ, 32'h0, "R2 request reads zero");
    readReg(8'h00, 32'h0, "R2 unmapped reads zero");

    // R5 flags follow inputs
    txFifoEmpty = 0; txComplete = 0;
    readReg(STAT, 32'h0000_0080, "R5 txfe/tc follow inputs");

    // R3/R4 transmit flush
    writeReq(REQ, 32'h10);
    check({28'h0, cap}, 32'h8, "R3 txFlushReq pulse only");
    txDataWrite = 1;
    @(negedge clk);
    check({31'h0, txFlushReq}, 32'h0, "R3 txFlushReq single cycle");
    check({31'h0, txPush}, 32'h0, "R4 push refused during flush");
    readReg(STAT, 32'h0, "R4 not-full low during flush");
    idle(3);
    @(negedge clk);
    check({31'h0, txPush}, 32'h0, "R4 push still refused");
    readReg(STAT, 32'h0, "R4 not-full still low");
    txDataWrite = 0;
    txFifoEmpty = 1;
    readReg(STAT, 32'h0080_0080, "R4 not-full back after empty");
    txDataWrite = 1;
    @(negedge clk);
    check({31'h0, txPush}, 32'h1, "R4 push accepted after flush");
    @(posedge clk); #1;
    txDataWrite = 0;
    txFifoFull = 1;
    readReg(STAT, 32'h0080_0000, "R5 not-full low when full");
    txFifoFull = 0; txComplete = 1;
    readReg(STAT, BASE, "R5 back to idle");

    // R6 receive flush
    rxFifoNotEmpty = 1;
    readReg(STAT, BASE | 32'h20, "R6 rxfne follows data");
    writeReq(REQ, 32'h08);
    check({28'h0, cap}, 32'h4, "R3 rxFlushReq pulse only");
    readReg(STAT, BASE, "R6 rxfne cleared by flush");
    readReg(STAT, BASE, "R6 rxfne held while input high");
    rxFifoNotEmpty = 0;
    readReg(STAT, BASE, "R6 fifo reported empty");
    rxFifoNotEmpty = 1;
    readReg(STAT, BASE | 32'h20, "R6 new data visible");
    rxFifoNotEmpty = 0;
    readReg(STAT, BASE, "R6 drained");

    // R7 mute and wake-up flag
    wakeEvent = 1; @(posedge clk); #1; wakeEvent = 0;
    readReg(STAT, BASE | 32'h0008_0000, "R7 wake sets flag");
    writeReq(REQ, 32'h04);
    check({28'h0, cap}, 32'h2, "R3 muteReq pulse only");
    readReg(STAT, BASE, "R7 mute clears flag");
    wakeEvent = 1; @(posedge clk); #1; wakeEvent = 0;
    readReg(STAT, BASE | 32'h0008_0000, "R7 wake sets flag again");
    wakeEvent = 1;
    writeReq(REQ, 32'h04);
    wakeEvent = 0;
    readReg(STAT, BASE, "R7 mute wins over wake");

    // R8/R9 break
    txIdle = 0;
    writeReq(REQ, 32'h02);
    check({28'h0, cap}, 32'h0, "R9 no breakReq while busy");
    readReg(STAT, BASE | 32'h0004_0000, "R8 break pending set");
    writeReq(REQ, 32'h02);
    check({28'h0, cap}, 32'h0, "R8 second break no pulse");
    readReg(STAT, BASE | 32'h0004_0000, "R8 second break no change");
    @(negedge clk);
    check({31'h0, breakReq}, 32'h0, "R9 held while busy");
    @(posedge clk); #1;
    txIdle = 1;
    @(negedge clk);
    check({31'h0, breakReq}, 32'h1, "R9 breakReq when idle");
    @(negedge clk);
    check({31'h0, breakReq}, 32'h0, "R9 breakReq one cycle");
    readReg(STAT, BASE | 32'h0004_0000, "R9 pending until done");
    breakDone = 1; @(posedge clk); #1; breakDone = 0;
    readReg(STAT, BASE, "R9 done clears pending");

    // R10 reserved bits and other addresses
    writeReq(REQ, 32'hFFFF_FFE1);
    check({28'h0, cap}, 32'h0, "R10 reserved bits no pulse");
    readReg(STAT, BASE, "R10 reserved bits no change");
    writeReq(8'h20, 32'h0000_001E);
    check({28'h0, cap}, 32'h0, "R10 other address no pulse");
    readReg(STAT, BASE, "R10 other address no change");

    // R3 combined request
    txIdle = 0;
    writeReq(REQ, 32'h0000_001E);
    check({28'h0, cap}, 32'hE, "R3 combined pulses");
    readReg(STAT, BASE | 32'h0004_0000, "R8 combined break pending");

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule